// File: doc/BRIEF.md
# Byte Shift Rotate Unit

This block carries out the single-operand bit-movement operations of an 8-bit microcontroller core: shift left, shift right, rotate left or right through the carry flag, arithmetic shift right, and exchange of the two nibbles. The core feeds it an operation code, the register operand and the current carry flag. It returns the new register value, the new status flag values and a mask telling the status register which flags to write.

Each operation takes one clock. When `in_valid` is high on a rising edge, the result, flags and write mask are captured into output registers. `out_valid` marks the cycle in which they are fresh. When `in_valid` is low, the registers keep their last values.

Top module: `bsr_unit`

## Requirements
- R1: After a synchronous reset, `out_valid`, `result`, `flags` and `flag_we` are all zero.
- R2: Op code 0 (shift left): result is the operand moved up one place with 0 in bit 0, and the new carry is old bit 7.
- R3: Op code 1 (shift right): result is the operand moved down one place with 0 in bit 7, and the new carry is old bit 0.
- R4: Op code 2 (rotate left through carry): bit 0 takes the incoming carry, the other bits move up one place, and the new carry is old bit 7.
- R5: Op code 3 (rotate right through carry): bit 7 takes the incoming carry, the other bits move down one place, and the new carry is old bit 0.
- R6: Op code 4 (arithmetic shift right): bits 7..1 move down into bits 6..0, bit 7 keeps its value, and the new carry is old bit 0.
- R7: Op code 5 (nibble swap): the upper and lower four bits exchange places, `flag_we` is 0000 and `flags` reads 0000.
- R8: For op codes 0 to 4, flag Z (`flags[1]`) is 1 exactly when the 8-bit result is zero, and flag N (`flags[2]`) equals result bit 7.
- R9: For op codes 0 to 4, flag V (`flags[3]`) equals the new N XOR the new C, and C is `flags[0]`.
- R10: For op codes 0 to 4, `flag_we` is 1111, enabling C, Z, N and V (bits 0, 1, 2, 3).
- R11: Outputs appear one cycle after `in_valid` is high, with `out_valid` high in that cycle. While `in_valid` is low, `out_valid` is low and `result`, `flags` and `flag_we` hold their values.
- R12: Op codes 6 and 7 are unused: `result` equals the operand, and both `flags` and `flag_we` are 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the operation |
| op | input | 3 | Operation code |
| operand | input | 8 | Register operand |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Registered outputs are fresh this cycle |
| result | output | 8 | New register value |
| flags | output | 4 | New flags: {V, N, Z, C} |
| flag_we | output | 4 | Per-flag write enable, same bit order as `flags` |

## Verification
The assertions assume the following about the inputs:
- `op`, `operand` and `carry_in` are stable around the rising edge on which `in_valid` is sampled.
- `in_valid` is a plain strobe that needs no handshake.
- Reset is held for at least one edge before the first operation.

The stimulus drives every input only on the falling clock edge and holds reset for several cycles. It then covers:
- every op code, including the two unused ones;
- back-to-back strobes and idle gaps, so that both the capture path and the hold path are exercised.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int OP_W   = 3;
  localparam int FLAG_W = 4;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_RTL  = 3'd2,
    OP_RTR  = 3'd3,
    OP_SAR  = 3'd4,
    OP_NSWP = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } bsr_op_e;
endpackage

// File: rtl/bsr_datapath.sv
module bsr_datapath
  import bsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] opnd,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int HALF = DATA_W / 2;
  localparam int MSB  = DATA_W - 1;

  always_comb begin
    res  = opnd;
    cout = 1'b0;
    case (bsr_op_e'(op))
      OP_SHL:  begin res = {opnd[MSB-1:0], 1'b0};     cout = opnd[MSB]; end
      OP_SHR:  begin res = {1'b0, opnd[MSB:1]};       cout = opnd[0];   end
      OP_RTL:  begin res = {opnd[MSB-1:0], cin};      cout = opnd[MSB]; end
      OP_RTR:  begin res = {cin, opnd[MSB:1]};        cout = opnd[0];   end
      OP_SAR:  begin res = {opnd[MSB], opnd[MSB:1]};  cout = opnd[0];   end
      OP_NSWP: res = {opnd[HALF-1:0], opnd[MSB:HALF]};
      default: res = opnd;
    endcase
  end
endmodule

// File: rtl/bsr_flags.sv
module bsr_flags
  import bsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] res,
  input  logic              cout,
  output logic [FLAG_W-1:0] flg,
  output logic [FLAG_W-1:0] we
);
  logic shift_class;
  logic n_bit;

  assign shift_class = (op <= OP_W'(OP_SAR));
  assign n_bit       = res[DATA_W-1];

  always_comb begin
    flg = '0;
    we  = '0;
    if (shift_class) begin
      flg[FC] = cout;
      flg[FZ] = ~|res;
      flg[FN] = n_bit;
      flg[FV] = n_bit ^ cout;
      we      = '1;
    end
  end
endmodule

// File: rtl/bsr_unit.sv
module bsr_unit
  import bsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags,
  output logic [3:0]        flag_we
);
  logic [DATA_W-1:0] res_d;
  logic              cout_d;
  logic [FLAG_W-1:0] flg_d;
  logic [FLAG_W-1:0] we_d;

  bsr_datapath #(.DATA_W(DATA_W)) u_dp (
    .op(op), .opnd(operand), .cin(carry_in), .res(res_d), .cout(cout_d)
  );

  bsr_flags #(.DATA_W(DATA_W)) u_fl (
    .op(op), .res(res_d), .cout(cout_d), .flg(flg_d), .we(we_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
      flag_we   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_d;
        flags   <= flg_d;
        flag_we <= we_d;
      end
    end
  end
endmodule

// File: rtl/bsr_unit_chk.sv
module bsr_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        flags,
  input logic [3:0]        flag_we
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && flags == '0 && flag_we == '0));

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r11_hold_result: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flags) && $stable(flag_we)));

  a_r7_swap_no_we: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd5) |=> (flag_we == 4'b0000));

  a_r10_shift_we: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op <= 3'd4) |=> (flag_we == 4'b1111));

  a_r9_v_flag: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_we[3]) |-> (flags[3] == (flags[2] ^ flags[0])));

  a_r8_zn_flags: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_we[1]) |-> (flags[1] == (result == '0) && flags[2] == result[DATA_W-1]));
endmodule

bind bsr_unit bsr_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
  .out_valid(out_valid), .result(result), .flags(flags), .flag_we(flag_we)
);

// File: tb/bsr_unit_bench.sv
module bsr_unit_bench;
  typedef struct {
    logic [7:0] res;
    logic [3:0] flg;
    logic [3:0] we;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] operand = '0;
  logic       carry_in = 1'b0;
  logic       out_valid;
  logic [7:0] result;
  logic [3:0] flags;
  logic [3:0] flag_we;

  int total = 0;
  int bad = 0;
  exp_t sb[$];
  logic [7:0] last_res;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  bsr_unit u_bsr_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .operand(operand),
    .carry_in(carry_in), .out_valid(out_valid), .result(result),
    .flags(flags), .flag_we(flag_we)
  );

  function automatic exp_t model(input logic [2:0] o, input logic [7:0] a, input logic c);
    exp_t e;
    logic co;
    co = 1'b0;
    e.we = 4'b1111;
    case (o)
      3'd0: begin e.res = a << 1; co = a[7]; e.req = "R2"; end
      3'd1: begin e.res = a >> 1; co = a[0]; e.req = "R3"; end
      3'd2: begin e.res = (a << 1) | {7'd0, c}; co = a[7]; e.req = "R4"; end
      3'd3: begin e.res = (a >> 1) | {c, 7'd0}; co = a[0]; e.req = "R5"; end
      3'd4: begin e.res = $signed(a) >>> 1; co = a[0]; e.req = "R6"; end
      3'd5: begin e.res = {a[3:0], a[7:4]}; e.we = 4'b0; e.req = "R7"; end
      default: begin e.res = a; e.we = 4'b0; e.req = "R12"; end
    endcase
    if (e.we != 0) e.flg = {e.res[7] ^ co, e.res[7], e.res == 8'd0, co};
    else e.flg = 4'b0;
    return e;
  endfunction

  task automatic issue(input logic [2:0] o, input logic [7:0] a, input logic c);
    @(negedge clk);
    in_valid = 1'b1; op = o; operand = a; carry_in = c;
    sb.push_back(model(o, a, c));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; op = 3'd7; operand = 8'hFF; carry_in = 1'b1;
    end
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares registered outputs against the scoreboard
  initial begin
    last_res = '0;
    forever begin
      @(negedge clk);
      if (!rst && !done) begin
        if (out_valid) begin
          if (sb.size() == 0) check("R11 unexpected out_valid", 16'd1, 16'd0);
          else begin
            exp_t e;
            e = sb.pop_front();
            check({e.req, " result"}, {8'd0, result}, {8'd0, e.res});
            check({e.req, " R8 R9 flags"}, {12'd0, flags}, {12'd0, e.flg});
            check({e.req, " R10 flag_we"}, {12'd0, flag_we}, {12'd0, e.we});
          end
          last_res = result;
        end else if (!$isunknown(in_valid)) begin
          check("R11 hold", {8'd0, result}, {8'd0, last_res});
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] lf;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {15'd0, out_valid}, 16'd0);
    check("R1 result", {8'd0, result}, 16'd0);
    check("R1 flags/we", {8'd0, flags, flag_we}, 16'd0);
    rst = 1'b0;
    // directed corner cases
    issue(3'd0, 8'h80, 1'b0);  // R2: zero result, C=1, V=1
    issue(3'd1, 8'h01, 1'b0);  // R3
    issue(3'd2, 8'h80, 1'b1);  // R4: carry enters bit 0
    issue(3'd3, 8'h01, 1'b1);  // R5: carry enters bit 7
    issue(3'd4, 8'h81, 1'b0);  // R6: sign kept
    issue(3'd4, 8'h7E, 1'b1);  // R6
    issue(3'd5, 8'hA5, 1'b1);  // R7
    issue(3'd6, 8'h3C, 1'b1);  // R12
    issue(3'd7, 8'h00, 1'b0);  // R12
    idle(3);                   // R11 hold
    issue(3'd2, 8'h00, 1'b0);  // R8 zero
    idle(1);
    issue(3'd5, 8'h00, 1'b0);  // R7 zero still no flags
    idle(2);
    lf = 8'h5B;
    for (int i = 0; i < 200; i++) begin
      issue(3'(i % 8), lf, lf[3]);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (i % 7 == 0) idle(1);
    end
    idle(3);
    done = 1'b1;
    check("R11 scoreboard drained", 16'(sb.size()), 16'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule